// File: doc/BRIEF.md
# Indirect Configuration RAM Access Port

This block places a 512-byte configuration store behind three byte-wide registers on a simple register bus. The store is laid out as 32 records of 16 bytes, so byte `n` of record `r` lives at pointer value `r*16 + n`. Software never addresses the store directly. It first loads a 9-bit internal pointer through two pointer registers. It then moves bytes through a single data window register.

Every data-window access, read or write, steps the pointer by one. Software can therefore stream a whole record, or the whole store, after a single pointer load. An access-permit input stands for the setup that must be complete before the store may be touched. While it is low, the data window is closed and the pointer stays where it is.

Top module: `cfg_ram_port`

## Requirements
- R1: After reset the pointer is 0x00F, so the low pointer register reads 0x0F and the high pointer register reads 0x00. `bus_rdata` holds 0xDC and `bus_rvalid` is low until the first read.
- R2: A write to offset 0xC3 while `access_ok` is high stores `bus_wdata` at the current pointer and then advances the pointer by one.
- R3: A read of offset 0xC3 while `access_ok` is high returns the byte at the current pointer on `bus_rdata`, with `bus_rvalid` high, in the cycle after the strobe. The pointer advances by one at the same edge.
- R4: A write to offset 0xC4 replaces pointer bits 7..0 with `bus_wdata` and keeps bit 8. A write to offset 0xC5 replaces pointer bit 8 with `bus_wdata[0]` and keeps bits 7..0. Either write takes effect at the next edge.
- R5: A read of offset 0xC4 returns pointer bits 7..0. A read of offset 0xC5 returns pointer bit 8 in bit 0, with bits 7..1 reading 0.
- R6: The pointer steps from 511 to 0.
- R7: While `access_ok` is low, writes to 0xC3 leave the store unchanged. Reads of 0xC3 return 0x00 with `bus_rvalid` high. In both cases the pointer does not move.
- R8: If `bus_wr` and `bus_rd` are both high in one cycle, only the write is performed. `bus_rvalid` stays low in the next cycle and `bus_rdata` keeps its value.
- R9: A read of any offset other than 0xC3, 0xC4 and 0xC5 returns 0x00 with `bus_rvalid` high. A write to such an offset changes neither the pointer nor the store.
- R10: `bus_rvalid` is high for exactly one cycle per accepted read. `bus_rdata` keeps its last value in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| access_ok | input | 1 | High when store access is permitted |
| bus_rdata | output | 8 | Read data, updated one cycle after an accepted read |
| bus_rvalid | output | 1 | High for the cycle in which `bus_rdata` carries fresh read data |

## Verification
Two functions can fall in the same cycle: a store write with its pointer step, and a read request. This happens when both strobes arrive together on the data window. The pointer step also meets a pointer-register load when a data access is followed at once by a write to 0xC4 or 0xC5. The bench raises both strobes together on random cycles and places pointer writes back to back with data accesses. It then judges the result from what follows. It reads the pointer registers and streams the store back, comparing against a bench model in which the write wins, the read is dropped and exactly one step occurs.

// File: rtl/cfg_ram_pkg.sv
// Package: shared types and register offsets for the indirect RAM port.
// Assumes an 8-bit register bus.
package cfg_ram_pkg;

    // Register offsets; software depends on these values.
    localparam logic [7:0] OFS_DATA = 8'hC3;
    localparam logic [7:0] OFS_PLO  = 8'hC4;
    localparam logic [7:0] OFS_PHI  = 8'hC5;

    // Reset values of the visible registers.
    localparam logic [7:0] DATA_RESET = 8'hDC;
    localparam logic [8:0] PTR_RESET  = 9'h00F;

    // One decoded bus operation per cycle.
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_DATA_WR = 3'd1,
        OP_DATA_RD = 3'd2,
        OP_PLO_WR  = 3'd3,
        OP_PHI_WR  = 3'd4,
        OP_PLO_RD  = 3'd5,
        OP_PHI_RD  = 3'd6,
        OP_ZERO_RD = 3'd7
    } bus_op_t;

endpackage

// File: rtl/cfg_ram_decode.sv
// Module: cfg_ram_decode
// Turns the raw bus strobes and offset into one operation code.
// Assumes at most one operation per cycle. A write strobe wins over a read strobe.
// A closed access permit turns data-window writes into no-ops and data-window reads into zero reads.
module cfg_ram_decode
    import cfg_ram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic          permit,
    output bus_op_t       op
);

    // Purpose: classify the current bus cycle.
    always_comb begin
        op = OP_NONE;
        if (wr) begin
            if (addr == AW'(OFS_DATA) && permit) op = OP_DATA_WR;
            else if (addr == AW'(OFS_PLO))       op = OP_PLO_WR;
            else if (addr == AW'(OFS_PHI))       op = OP_PHI_WR;
        end else if (rd) begin
            if (addr == AW'(OFS_DATA))           op = permit ? OP_DATA_RD : OP_ZERO_RD;
            else if (addr == AW'(OFS_PLO))       op = OP_PLO_RD;
            else if (addr == AW'(OFS_PHI))       op = OP_PHI_RD;
            else                                 op = OP_ZERO_RD;
        end
    end

endmodule

// File: rtl/cfg_ram_ptr.sv
// Module: cfg_ram_ptr
// Holds the store pointer.
// Loads from either pointer register and steps by one on each data-window access.
// Wraps at the store size.
// Assumes the store size is 2**PTR_W, so natural overflow gives the wrap.
module cfg_ram_ptr
    import cfg_ram_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_op_t          op,
    input  logic [DW-1:0]    wdata,
    output logic [PTR_W-1:0] ptr
);

    localparam int HI_W = PTR_W - DW;

    logic step;
    logic load;

    // Purpose: flag the operations that move or load the pointer.
    always_comb begin
        step = (op == OP_DATA_WR) || (op == OP_DATA_RD);
        load = (op == OP_PLO_WR) || (op == OP_PHI_WR);
    end

    // Purpose: update the pointer from a load or a step.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= PTR_W'(PTR_RESET);
        else if (op == OP_PLO_WR)  ptr[DW-1:0] <= wdata;
        else if (op == OP_PHI_WR)  ptr[PTR_W-1:DW] <= wdata[HI_W-1:0];
        else if (step)             ptr <= ptr + 1'b1;
    end

    // A data-window access advances the pointer by one, wrapping (R2, R3, R6).
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ptr == PTR_W'($past(ptr) + 1'b1));

    // With no access and no load the pointer holds (R7, R9).
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(ptr));

    // A low-byte load keeps the high part (R4).
    assert_plo_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PLO_WR) |=> ptr[PTR_W-1:DW] == $past(ptr[PTR_W-1:DW]));

endmodule

// File: rtl/cfg_ram_store.sv
// Module: cfg_ram_store
// Byte-wide store of DEPTH entries.
// Synchronous write, combinational read at the same address.
// Assumes the caller supplies one address for both ports. Contents are not reset.
module cfg_ram_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Purpose: commit a byte on a write enable.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Purpose: present the byte at the current address.
    always_comb rdata = mem[addr];

endmodule

// File: rtl/cfg_ram_port.sv
// Module: cfg_ram_port (top)
// Register-bus access to a configuration store through a data window and a split pointer.
// Assumes single-cycle strobes and DW=8.
// Read data registers one cycle after the strobe. The pointer step lands on the same edge,
// after the byte at the old pointer has been captured.
module cfg_ram_port
    import cfg_ram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int RAM_BYTES = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          access_ok,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvalid
);

    localparam int PTR_W = $clog2(RAM_BYTES);

    bus_op_t          op;
    logic [PTR_W-1:0] ptr;
    logic [DW-1:0]    ram_q;
    logic [DW-1:0]    rd_next;
    logic             rd_take;

    cfg_ram_decode #(.AW(AW)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .permit (access_ok),
        .op     (op)
    );

    cfg_ram_ptr #(.DW(DW), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wdata (bus_wdata),
        .ptr   (ptr)
    );

    cfg_ram_store #(.DW(DW), .DEPTH(RAM_BYTES)) u_ram (
        .clk   (clk),
        .we    (op == OP_DATA_WR),
        .addr  (ptr),
        .wdata (bus_wdata),
        .rdata (ram_q)
    );

    // Purpose: pick the read value for the current operation.
    always_comb begin
        rd_take = 1'b1;
        rd_next = '0;
        unique case (op)
            OP_DATA_RD: rd_next = ram_q;
            OP_PLO_RD:  rd_next = ptr[DW-1:0];
            OP_PHI_RD:  rd_next = DW'(ptr[PTR_W-1:DW]);
            OP_ZERO_RD: rd_next = '0;
            default:    rd_take = 1'b0;
        endcase
    end

    // Purpose: register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= DW'(DATA_RESET);
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_take;
            if (rd_take) bus_rdata <= rd_next;
        end
    end

    // A lone read strobe yields valid data next cycle (R3, R10).
    assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    // Both strobes together: no read response (R8).
    assert_both_norsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> !bus_rvalid);

    // Closed permit: data-window read returns zero (R7).
    assert_deny_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !access_ok && bus_addr == AW'(OFS_DATA)) |=> bus_rdata == '0);

    // Without a response the read data holds (R10).
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> $stable(bus_rdata));

endmodule

// File: tb/sim_cfg_ram_port.sv
`timescale 1ns/1ps
module sim_cfg_ram_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       access_ok = 1'b1;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;

    always #2.5 clk = ~clk;

    cfg_ram_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .access_ok(access_ok),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 0;
    logic [7:0] mdl_mem [512];
    logic [8:0] mdl_ptr;
    logic [7:0] mdl_last;

    // Expected read result for an offset, from the requirements.
    function automatic logic [7:0] calc_read(input logic [7:0] a, input logic ok);
        if (a == 8'hC3) return ok ? mdl_mem[mdl_ptr] : 8'h00;   // R3, R7
        if (a == 8'hC4) return mdl_ptr[7:0];                     // R5
        if (a == 8'hC5) return {7'b0, mdl_ptr[8]};               // R5
        return 8'h00;                                            // R9
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, update the model, check at the next falling edge.
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [7:0] d, input logic ok, input string tag);
        logic       ev;
        logic [7:0] ed;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; access_ok = ok;
        ev = 1'b0;
        ed = mdl_last;
        if (wr) begin
            if (a == 8'hC3 && ok) begin mdl_mem[mdl_ptr] = d; mdl_ptr = mdl_ptr + 1'b1; end
            else if (a == 8'hC4) mdl_ptr[7:0] = d;
            else if (a == 8'hC5) mdl_ptr[8] = d[0];
        end else if (rd) begin
            ev = 1'b1;
            ed = calc_read(a, ok);
            if (a == 8'hC3 && ok) mdl_ptr = mdl_ptr + 1'b1;
        end
        mdl_last = ed;
        @(negedge clk);
        check(tag, {7'b0, bus_rvalid}, {7'b0, ev});
        check(tag, bus_rdata, ed);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        mdl_ptr = 9'h00F;
        mdl_last = 8'hDC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {7'b0, bus_rvalid}, 8'h00);
        check("R1", bus_rdata, 8'hDC);
        step(0, 1, 8'hC4, 0, 1, "R1");
        step(0, 1, 8'hC5, 0, 1, "R1");
        // R2, R6: burst fill of the whole store from 0x00F, wrapping past 511
        for (int i = 0; i < 512; i++) step(1, 0, 8'hC3, 8'($urandom), 1, "R2");
        step(0, 1, 8'hC4, 0, 1, "R6");
        step(0, 1, 8'hC5, 0, 1, "R6");
        // R3: stream back one record
        step(1, 0, 8'hC4, 8'h20, 1, "R4");
        for (int i = 0; i < 16; i++) step(0, 1, 8'hC3, 0, 1, "R3");
        // R6: wrap on a data read from 0x1FF
        step(1, 0, 8'hC5, 8'hFF, 1, "R4");
        step(1, 0, 8'hC4, 8'hFF, 1, "R4");
        step(0, 1, 8'hC5, 0, 1, "R5");
        step(0, 1, 8'hC3, 0, 1, "R6");
        step(0, 1, 8'hC4, 0, 1, "R6");
        step(0, 1, 8'hC5, 0, 1, "R6");
        // R7: closed permit
        step(1, 0, 8'hC3, 8'hA5, 0, "R7");
        step(0, 1, 8'hC3, 0, 0, "R7");
        step(0, 1, 8'hC4, 0, 1, "R7");
        step(0, 1, 8'hC3, 0, 1, "R7");
        // R8: both strobes, followed at once by a pointer load
        step(1, 1, 8'hC3, 8'h3C, 1, "R8");
        step(1, 0, 8'hC4, 8'h01, 1, "R8");
        step(0, 1, 8'hC3, 0, 1, "R8");
        // R9: other offsets
        step(1, 0, 8'h10, 8'h77, 1, "R9");
        step(0, 1, 8'h10, 0, 1, "R9");
        step(0, 1, 8'hC4, 0, 1, "R9");
        // Random mix
        for (int i = 0; i < 6000; i++) begin
            int         k;
            logic       ok;
            logic [7:0] d;
            k  = $urandom_range(0, 9);
            ok = ($urandom_range(0, 4) != 0);
            d  = 8'($urandom);
            case (k)
                0, 1: step(1, 0, 8'hC3, d, ok, "R2");
                2, 3: step(0, 1, 8'hC3, 0, ok, "R3");
                4:    step(1, 0, 8'hC4, d, ok, "R4");
                5:    step(1, 0, 8'hC5, d, ok, "R4");
                6:    step(0, 1, $urandom_range(0, 1) ? 8'hC4 : 8'hC5, 0, ok, "R5");
                7:    step(1, 1, 8'hC3, d, ok, "R8");
                8:    step($urandom_range(0, 1), 1'b0 , 8'($urandom), d, ok, "R10");
                default: step(0, 1, 8'(k * 3), 0, ok, "R9");
            endcase
        end
        // Final full read-back
        step(1, 0, 8'hC5, 0, 1, "R4");
        step(1, 0, 8'hC4, 0, 1, "R4");
        for (int i = 0; i < 512; i++) step(0, 1, 8'hC3, 0, 1, "R3");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule